// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block tracks link reservations for a data cache shared by several requesters. Completion events for cache accesses arrive on a number of parallel event ports. Each event carries a line address, a requester id and an access kind. A load-linked completion reserves its line for the issuing requester. A later store-conditional from that requester succeeds only while the reservation is still in place. Store-conditionals always drop the reservation on their line, and ordinary stores by the owner drop it too.

For every accepted event the monitor returns a registered result one cycle later: a valid pulse and a success flag. For read-modify-write sequences it also raises a block or unblock control for the event's line, so that the cache controller can hold off other traffic to that line between the read half and the write half. The reservation store is a small fully associative table. At most one entry covers a given line.

Within one cycle, every port is evaluated against the table as it stood at the start of that cycle. All clearing effects of the cycle are applied before any new reservation.

Top module: `llsc_monitor`

## Requirements
- R1: A load-linked event (kind code 2) reserves its line for its requester id, and its result flag is 1.
- R2: A store-conditional event (kind code 3) reports flag 1 only if its line is reserved by the same requester id; otherwise it reports flag 0.
- R3: Every store-conditional removes the reservation on its line, whether it succeeds or fails and whoever owns the reservation.
- R4: A store (kind 1), read-modify-write read (kind 4) or read-modify-write write (kind 5) removes the reservation on its line only when the event's requester id owns it. A plain load (kind 0) never changes any reservation.
- R5: Every event whose kind is not store-conditional reports flag 1.
- R6: A read-modify-write read (kind 4) raises the block output, and a read-modify-write write (kind 5) raises the unblock output. Each is raised for exactly the result cycle, with that event's line on the control line output. All other kinds raise neither.
- R7: The table has 4 entries. A load-linked to a line that is already reserved overwrites that entry's owner. Otherwise it takes the lowest free entry, and if none is free it replaces entry 0.
- R8: The result valid, flag, block, unblock and line outputs are registered. They reflect an event exactly one clock after it is presented, and the valid, block and unblock outputs are 0 in cycles that follow no event.
- R9: After reset no reservation is held and all outputs are 0.
- R10: In one cycle, results use the table from the start of the cycle. Clears from all ports are applied first, then load-linked reservations in port order. A load-linked and a store-conditional to the same line in the same cycle therefore leave the new reservation in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | NP | Event present, one bit per port |
| evt_kind | input | 3*NP | Access kind per port (0 load, 1 store, 2 load-linked, 3 store-conditional, 4 RMW read, 5 RMW write) |
| evt_line | input | LINE_W*NP | Line address per port |
| evt_rid | input | RID_W*NP | Requester id per port |
| res_valid | output | NP | Result valid, one cycle after the event |
| res_ok | output | NP | Success flag |
| blk_req | output | NP | Block the line (RMW read completed) |
| unblk_req | output | NP | Unblock the line (RMW write completed) |
| ctl_line | output | LINE_W*NP | Line the result and block controls refer to |

## Verification
Store-conditionals are tried in several situations: after a load-linked by the same requester, after one by a different requester, after an earlier store-conditional, and after ordinary stores by the owner and by another requester. These cases separate an owner check from a plain line check, and a clear on success from a clear on every attempt. A full table followed by one more load-linked shows whether replacement hits entry 0 or another slot. Two ports that carry a store-conditional and a load-linked to the same line in one cycle show whether clears come before new reservations. Read-modify-write pairs and plain loads show that the block controls follow the kind alone and that loads leave reservations untouched.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    localparam int LINE_W = 26;
    localparam int RID_W  = 2;
    localparam int KIND_W = 3;

    typedef enum logic [KIND_W-1:0] {
        K_LOAD   = 3'd0,
        K_STORE  = 3'd1,
        K_LL     = 3'd2,
        K_SC     = 3'd3,
        K_RMW_RD = 3'd4,
        K_RMW_WR = 3'd5
    } acc_kind_e;

    typedef struct packed {
        logic              vld;
        logic [LINE_W-1:0] line;
        logic [RID_W-1:0]  rid;
    } rsv_entry_t;

    typedef struct packed {
        logic              vld;
        acc_kind_e         kind;
        logic [LINE_W-1:0] line;
        logic [RID_W-1:0]  rid;
    } acc_evt_t;

    // Kinds that drop the reservation only when issued by its owner.
    function automatic logic owner_clears(acc_kind_e k);
        return (k == K_STORE) || (k == K_RMW_RD) || (k == K_RMW_WR);
    endfunction

endpackage

// File: rtl/rsv_match.sv
module rsv_match
    import llsc_pkg::*;
#(
    parameter int NE = 4
) (
    input  rsv_entry_t [NE-1:0] tbl,
    input  logic [LINE_W-1:0]   line,
    input  logic [RID_W-1:0]    rid,
    output logic                hit_owner
);
    logic [NE-1:0] own_vec;

    for (genvar e = 0; e < NE; e++) begin : g_ent
        assign own_vec[e] = tbl[e].vld && (tbl[e].line == line) && (tbl[e].rid == rid);
    end

    assign hit_owner = |own_vec;
endmodule

// File: rtl/rsv_next.sv
module rsv_next
    import llsc_pkg::*;
#(
    parameter int NE = 4,
    parameter int NP = 2
) (
    input  rsv_entry_t [NE-1:0] cur,
    input  acc_evt_t   [NP-1:0] evt,
    output rsv_entry_t [NE-1:0] nxt
);
    localparam int IDX_W = (NE > 1) ? $clog2(NE) : 1;

    rsv_entry_t [NE-1:0] cleared;
    logic [IDX_W-1:0]    slot;
    logic                have_same;
    logic                have_free;

    always_comb begin
        // Pass 1: all clears of this cycle, judged against the current table.
        cleared = cur;
        for (int p = 0; p < NP; p++) begin
            if (evt[p].vld) begin
                for (int e = 0; e < NE; e++) begin
                    if (cur[e].vld && cur[e].line == evt[p].line) begin
                        if (evt[p].kind == K_SC)
                            cleared[e].vld = 1'b0;
                        else if (owner_clears(evt[p].kind) && cur[e].rid == evt[p].rid)
                            cleared[e].vld = 1'b0;
                    end
                end
            end
        end

        // Pass 2: new reservations in port order.
        nxt       = cleared;
        slot      = '0;
        have_same = 1'b0;
        have_free = 1'b0;
        for (int p = 0; p < NP; p++) begin
            if (evt[p].vld && evt[p].kind == K_LL) begin
                slot      = '0;
                have_same = 1'b0;
                have_free = 1'b0;
                for (int e = 0; e < NE; e++) begin
                    if (!have_same && nxt[e].vld && nxt[e].line == evt[p].line) begin
                        have_same = 1'b1;
                        slot      = IDX_W'(e);
                    end
                end
                if (!have_same) begin
                    for (int e = 0; e < NE; e++) begin
                        if (!have_free && !nxt[e].vld) begin
                            have_free = 1'b1;
                            slot      = IDX_W'(e);
                        end
                    end
                end
                nxt[slot].vld  = 1'b1;
                nxt[slot].line = evt[p].line;
                nxt[slot].rid  = evt[p].rid;
            end
        end
    end
endmodule

// File: rtl/rsv_resp.sv
module rsv_resp
    import llsc_pkg::*;
#(
    parameter int NP = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  acc_evt_t   [NP-1:0]      evt,
    input  logic       [NP-1:0]      owner_hit,
    output logic       [NP-1:0]      res_valid,
    output logic       [NP-1:0]      res_ok,
    output logic       [NP-1:0]      blk_req,
    output logic       [NP-1:0]      unblk_req,
    output logic [NP*LINE_W-1:0]     ctl_line
);
    for (genvar p = 0; p < NP; p++) begin : g_port
        always_ff @(posedge clk) begin
            if (rst) begin
                res_valid[p]                     <= 1'b0;
                res_ok[p]                        <= 1'b0;
                blk_req[p]                       <= 1'b0;
                unblk_req[p]                     <= 1'b0;
                ctl_line[p*LINE_W +: LINE_W]     <= '0;
            end else begin
                res_valid[p] <= evt[p].vld;
                res_ok[p]    <= evt[p].vld && ((evt[p].kind == K_SC) ? owner_hit[p] : 1'b1);
                blk_req[p]   <= evt[p].vld && (evt[p].kind == K_RMW_RD);
                unblk_req[p] <= evt[p].vld && (evt[p].kind == K_RMW_WR);
                if (evt[p].vld)
                    ctl_line[p*LINE_W +: LINE_W] <= evt[p].line;
            end
        end
    end
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int NP = 2,
    parameter int NE = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NP-1:0]        evt_valid,
    input  logic [NP*KIND_W-1:0] evt_kind,
    input  logic [NP*LINE_W-1:0] evt_line,
    input  logic [NP*RID_W-1:0]  evt_rid,
    output logic [NP-1:0]        res_valid,
    output logic [NP-1:0]        res_ok,
    output logic [NP-1:0]        blk_req,
    output logic [NP-1:0]        unblk_req,
    output logic [NP*LINE_W-1:0] ctl_line
);
    acc_evt_t   [NP-1:0] evt;
    rsv_entry_t [NE-1:0] tbl_q;
    rsv_entry_t [NE-1:0] tbl_d;
    logic       [NP-1:0] owner_hit;
    logic       [NE-1:0] rsv_vld;

    for (genvar p = 0; p < NP; p++) begin : g_port
        assign evt[p].vld  = evt_valid[p];
        assign evt[p].kind = acc_kind_e'(evt_kind[p*KIND_W +: KIND_W]);
        assign evt[p].line = evt_line[p*LINE_W +: LINE_W];
        assign evt[p].rid  = evt_rid[p*RID_W +: RID_W];

        rsv_match #(.NE(NE)) u_match (
            .tbl       (tbl_q),
            .line      (evt[p].line),
            .rid       (evt[p].rid),
            .hit_owner (owner_hit[p])
        );
    end

    for (genvar e = 0; e < NE; e++) begin : g_vld
        assign rsv_vld[e] = tbl_q[e].vld;
    end

    rsv_next #(.NE(NE), .NP(NP)) u_next (
        .cur (tbl_q),
        .evt (evt),
        .nxt (tbl_d)
    );

    always_ff @(posedge clk) begin
        if (rst)
            tbl_q <= '0;
        else
            tbl_q <= tbl_d;
    end

    rsv_resp #(.NP(NP)) u_resp (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .owner_hit (owner_hit),
        .res_valid (res_valid),
        .res_ok    (res_ok),
        .blk_req   (blk_req),
        .unblk_req (unblk_req),
        .ctl_line  (ctl_line)
    );
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk
    import llsc_pkg::*;
#(
    parameter int NP = 2,
    parameter int NE = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NP-1:0]        evt_valid,
    input logic [NP*KIND_W-1:0] evt_kind,
    input logic [NP-1:0]        res_valid,
    input logic [NP-1:0]        res_ok,
    input logic [NP-1:0]        blk_req,
    input logic [NP-1:0]        unblk_req,
    input logic [NE-1:0]        rsv_vld
);
    // R9: reset leaves no reservation and quiet outputs
    p_reset_empty_r9: assert property (@(posedge clk)
        rst |=> (rsv_vld == '0) && (res_valid == '0) && (blk_req == '0) && (unblk_req == '0));

    for (genvar p = 0; p < NP; p++) begin : g_p
        // R8: result pulse exactly one cycle after an event
        p_res_follows_r8: assert property (@(posedge clk) disable iff (rst)
            evt_valid[p] |=> res_valid[p]);
        p_res_quiet_r8: assert property (@(posedge clk) disable iff (rst)
            !evt_valid[p] |=> !res_valid[p] && !blk_req[p] && !unblk_req[p]);
        // R5: non-conditional kinds always report success
        p_plain_ok_r5: assert property (@(posedge clk) disable iff (rst)
            (evt_valid[p] && evt_kind[p*KIND_W +: KIND_W] != K_SC) |=> res_ok[p]);
        // R6: block for RMW read, unblock for RMW write
        p_blk_r6: assert property (@(posedge clk) disable iff (rst)
            (evt_valid[p] && evt_kind[p*KIND_W +: KIND_W] == K_RMW_RD) |=> blk_req[p] && !unblk_req[p]);
        p_unblk_r6: assert property (@(posedge clk) disable iff (rst)
            (evt_valid[p] && evt_kind[p*KIND_W +: KIND_W] == K_RMW_WR) |=> unblk_req[p] && !blk_req[p]);
        // R3: a store-conditional never leaves a load-linked-free table growing
        p_sc_no_alloc_r3: assert property (@(posedge clk) disable iff (rst)
            (evt_valid == NP'(1) << p && evt_kind[p*KIND_W +: KIND_W] == K_SC)
            |=> $countones(rsv_vld) <= $countones($past(rsv_vld)));
    end
endmodule

bind llsc_monitor llsc_monitor_chk #(.NP(NP), .NE(NE)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .evt_valid (evt_valid),
    .evt_kind  (evt_kind),
    .res_valid (res_valid),
    .res_ok    (res_ok),
    .blk_req   (blk_req),
    .unblk_req (unblk_req),
    .rsv_vld   (rsv_vld)
);

// File: tb/llsc_monitor_test.sv
module llsc_monitor_test;
    localparam int NP = 2;
    localparam int LW = 26;
    localparam int RW = 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NP-1:0]   evt_valid = '0;
    logic [NP*3-1:0] evt_kind  = '0;
    logic [NP*LW-1:0] evt_line = '0;
    logic [NP*RW-1:0] evt_rid  = '0;
    logic [NP-1:0]   res_valid, res_ok, blk_req, unblk_req;
    logic [NP*LW-1:0] ctl_line;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    llsc_monitor #(.NP(NP), .NE(4)) uut (
        .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_kind(evt_kind),
        .evt_line(evt_line), .evt_rid(evt_rid), .res_valid(res_valid),
        .res_ok(res_ok), .blk_req(blk_req), .unblk_req(unblk_req), .ctl_line(ctl_line)
    );

    // {kind[15:13], line[12:5], rid[4:3], ok, blk, unblk}
    localparam logic [15:0] VEC [20] = '{
        {3'd2, 8'd10, 2'd1, 3'b100},  // LL 10 by 1
        {3'd3, 8'd10, 2'd2, 3'b000},  // SC by other fails, clears
        {3'd3, 8'd10, 2'd1, 3'b000},  // owner now fails
        {3'd2, 8'd10, 2'd1, 3'b100},
        {3'd3, 8'd10, 2'd1, 3'b100},  // succeeds
        {3'd3, 8'd10, 2'd1, 3'b000},  // cleared by success
        {3'd2, 8'd20, 2'd0, 3'b100},
        {3'd1, 8'd20, 2'd3, 3'b100},  // store by non-owner keeps lock
        {3'd3, 8'd20, 2'd0, 3'b100},
        {3'd2, 8'd30, 2'd2, 3'b100},
        {3'd1, 8'd30, 2'd2, 3'b100},  // owner store clears
        {3'd3, 8'd30, 2'd2, 3'b000},
        {3'd2, 8'd40, 2'd1, 3'b100},
        {3'd2, 8'd40, 2'd3, 3'b100},  // same line, owner becomes 3
        {3'd3, 8'd40, 2'd1, 3'b000},
        {3'd2, 8'd40, 2'd3, 3'b100},
        {3'd3, 8'd40, 2'd3, 3'b100},
        {3'd4, 8'd50, 2'd0, 3'b110},  // RMW read -> block
        {3'd5, 8'd50, 2'd0, 3'b101},  // RMW write -> unblock
        {3'd0, 8'd60, 2'd0, 3'b100}   // plain load
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    // Present one cycle of events; results are sampled one negedge later.
    task automatic step(input logic v0, input logic [2:0] k0, input logic [7:0] l0, input logic [1:0] r0,
                        input logic v1, input logic [2:0] k1, input logic [7:0] l1, input logic [1:0] r1);
        evt_valid = {v1, v0};
        evt_kind  = {k1, k0};
        evt_line  = {LW'(l1), LW'(l0)};
        evt_rid   = {r1, r0};
        @(negedge clk);
        evt_valid = '0;
    endtask

    task automatic one(input logic [2:0] k, input logic [7:0] l, input logic [1:0] r);
        step(1'b1, k, l, r, 1'b0, 3'd0, 8'd0, 2'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R9 reset outputs", {28'd0, res_valid, blk_req}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        one(3'd3, 8'd10, 2'd1);
        chk("R9 no reservation after reset", {31'd0, res_ok[0]}, 32'd0);
        @(negedge clk);
        chk("R8 idle cycle quiet", {29'd0, res_valid[0], blk_req[0], unblk_req[0]}, 32'd0);

        for (int i = 0; i < 20; i++) begin
            one(VEC[i][15:13], VEC[i][12:5], VEC[i][4:3]);
            chk($sformatf("R1 R2 R3 R4 R5 R6 R8 table step %0d", i),
                {28'd0, res_valid[0], res_ok[0], blk_req[0], unblk_req[0]},
                {28'd0, 1'b1, VEC[i][2:0]});
            chk($sformatf("R6 R8 line step %0d", i), 32'(ctl_line[LW-1:0]), 32'(VEC[i][12:5]));
        end

        // R4: plain load by owner leaves reservation
        one(3'd2, 8'd70, 2'd1);
        one(3'd0, 8'd70, 2'd1);
        one(3'd3, 8'd70, 2'd1);
        chk("R4 load does not clear", {31'd0, res_ok[0]}, 32'd1);
        // R4: RMW write by owner clears
        one(3'd2, 8'd71, 2'd2);
        one(3'd5, 8'd71, 2'd2);
        one(3'd3, 8'd71, 2'd2);
        chk("R4 RMW by owner clears", {31'd0, res_ok[0]}, 32'd0);

        // R7: fill all four entries then replace entry 0
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        one(3'd2, 8'd1, 2'd0);
        one(3'd2, 8'd2, 2'd1);
        one(3'd2, 8'd3, 2'd2);
        one(3'd2, 8'd4, 2'd3);
        one(3'd2, 8'd5, 2'd0);
        one(3'd3, 8'd1, 2'd0);
        chk("R7 entry 0 replaced", {31'd0, res_ok[0]}, 32'd0);
        one(3'd3, 8'd2, 2'd1);
        chk("R7 other entry kept", {31'd0, res_ok[0]}, 32'd1);
        one(3'd3, 8'd5, 2'd0);
        chk("R7 new reservation", {31'd0, res_ok[0]}, 32'd1);

        // R10: SC on port 0 and LL on port 1, same line, same cycle
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        step(1'b1, 3'd3, 8'd7, 2'd2, 1'b1, 3'd2, 8'd7, 2'd2);
        chk("R10 both ports valid", {30'd0, res_valid}, 32'd3);
        chk("R10 SC against old table", {30'd0, res_ok}, 32'd2);
        one(3'd3, 8'd7, 2'd2);
        chk("R10 LL survives same-cycle clear", {31'd0, res_ok[0]}, 32'd1);
        // R2: port 1 path, owner mismatch
        step(1'b1, 3'd2, 8'd9, 2'd0, 1'b0, 3'd0, 8'd0, 2'd0);
        step(1'b0, 3'd0, 8'd0, 2'd0, 1'b1, 3'd3, 8'd9, 2'd1);
        chk("R2 port 1 wrong owner", {30'd0, res_ok}, 32'd0);
        chk("R6 port 1 line", 32'(ctl_line[2*LW-1:LW]), 32'd9);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule